// File: doc/BRIEF.md
# Keyed Independent Watchdog Timer

This block is a watchdog that counts down on a slow-clock enable strobe. It raises a one-cycle reset pulse when software stops refreshing it. A 12-bit down-counter is decremented by a programmable prescaler. Software controls the block through magic values written to a key register: one key starts the watchdog, one refreshes the counter, and one unlocks the configuration registers. The configuration registers hold the prescaler select, the reload value and the window limit. A value written to one of them does not take effect at once. It is marked pending in a status register until a fixed number of slow ticks has passed, and only then does the counter use it.

Once started, the watchdog runs until system reset. A static hardware-start input can start it without any key write. An optional window rejects a refresh that comes while the counter is still above the window limit, and such a refresh fires the reset pulse at once. A debug-freeze configuration input, combined with a core-halted input, stops the count. A sticky flag records that a watchdog reset pulse occurred. Software clears it through the status register.

Register writes use a valid/ready port. `wr_ready` is held high, so the block never applies back-pressure, and a write is taken on every clock edge where `wr_valid` is high. Reads are combinational from `rd_addr`. Register addresses: 0 key, 1 prescaler, 2 reload, 3 window, 4 status.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is inactive and `wdt_reset` is low. Prescaler reads 0, reload reads 0xFFF, window reads 0xFFF and status reads 0.
- R2: Writing 0xCCCC to the key register sets `active`. Once `active` is high, only reset clears it, whatever keys are written. With `hw_start` high, the block becomes active after reset without any key write.
- R3: Writing 0x5555 to the key register unlocks the prescaler, reload and window registers. While locked, writes to those registers are ignored. Any key value other than 0xCCCC, 0xAAAA or 0x5555 locks them again.
- R4: Writing 0xAAAA loads the applied reload value R into the counter and restarts the prescaler. With `slow_tick` high every cycle and divide factor D, `wdt_reset` pulses exactly D*R clocks after that write.
- R5: The reset pulse is one clock wide. At the next prescaler strobe after reaching zero, the counter reloads from the reload value and keeps counting, so the next pulse comes D*(R+1) clocks after the first.
- R6: The prescaler select is bits 2:0 of register 1 and gives a divide factor of 4 << sel. Select values above 6 act as 6, which divides by 256.
- R7: Status bit 0 (prescaler), bit 1 (reload) and bit 2 (window) go high on an accepted write to that register. Each stays high for 5 slow ticks, after which the new value is applied and the bit clears.
- R8: An accepted write to the window register reloads the counter from the applied reload value and restarts the prescaler.
- R9: While active with an applied window W other than 0xFFF, a 0xAAAA key written while the counter is above W fires `wdt_reset` in the next cycle. A 0xAAAA key written at or below W does not.
- R10: With `freeze_cfg` and `dbg_halt` both high, the counter does not advance. With `freeze_cfg` low, `dbg_halt` has no effect.
- R11: Status bit 3 is set after each reset pulse. Writing the status register with bit 3 high clears it, and this write needs no unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-oscillator period |
| hw_start | input | 1 | Static option: start without a key write |
| freeze_cfg | input | 1 | Allows the debug halt to stop counting |
| dbg_halt | input | 1 | Core halted in debug |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (held high) |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 16 | Read data for rd_addr |
| active | output | 1 | Watchdog running (also forces the slow oscillator on) |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |

## Verification
The one-cycle pulse property assumes software never writes two refresh keys on back-to-back cycles while the window is armed. Such a pair would trigger two window violations in a row. The stimulus always leaves at least one cycle between key writes, because each write task drives the request for a single edge and then returns to idle. The timing checks assume `slow_tick` is held high, which makes the prescaler strobe cycles exact. The bench holds it high throughout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;

  localparam logic [ADDR_W-1:0] A_KEY    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_WINDOW = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam int STICKY_BIT = 3;

  typedef struct packed {
    logic start;
    logic refresh;
    logic unlock;
    logic relock;
  } key_evt_t;
endpackage

// File: rtl/wdg_key_decode.sv
module wdg_key_decode
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output key_evt_t          evt,
  output logic              unlocked
);
  always_comb begin
    evt = '0;
    if (key_wr) begin
      unique case (key_val)
        KEY_START:   evt.start   = 1'b1;
        KEY_REFRESH: evt.refresh = 1'b1;
        KEY_UNLOCK:  evt.unlock  = 1'b1;
        default:     evt.relock  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          unlocked <= 1'b0;
    else if (evt.unlock) unlocked <= 1'b1;
    else if (evt.relock) unlocked <= 1'b0;
  end
endmodule

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int              W         = 12,
  parameter logic [W-1:0]    RST_VAL   = '1,
  parameter int              UPD_TICKS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] applied,
  output logic         pending
);
  localparam int AGE_W = $clog2(UPD_TICKS + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(UPD_TICKS - 1);

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= RST_VAL;
      applied <= RST_VAL;
      pending <= 1'b0;
      age     <= '0;
    end else if (wr_en) begin
      shadow  <= wr_val;
      pending <= 1'b1;
      age     <= '0;
    end else if (pending && slow_tick) begin
      if (age == AGE_LAST) begin
        applied <= shadow;
        pending <= 1'b0;
      end else begin
        age <= age + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 6,
  parameter int PRE_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_SEL);

  logic [SEL_W-1:0] sel_c;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;
  logic [PRE_W-1:0] pre_q;

  always_comb begin
    sel_c  = (sel > SEL_CAP) ? SEL_CAP : sel;
    span   = (PRE_W+1)'(4) << sel_c;
    limit  = PRE_W'(span - 1'b1);
    strobe = run_en && !restart && (pre_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run_en)  pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_downcounter.sv
module wdg_downcounter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = strobe && !load && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '1;
    else if (load)   cnt <= load_val;
    else if (strobe) cnt <= (cnt == '0) ? load_val : cnt - 1'b1;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdg_pkg::*;
#(
  parameter int UPD_TICKS = 5,
  parameter int MAX_SEL   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              hw_start,
  input  logic              freeze_cfg,
  input  logic              dbg_halt,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              active,
  output logic              wdt_reset
);
  localparam logic [CNT_W-1:0] WIN_OFF = '1;

  logic             wr_fire;
  key_evt_t         kev;
  logic             unlocked;
  logic             presc_we, reload_we, window_we;
  logic [SEL_W-1:0] presc_sh, presc_ap;
  logic [CNT_W-1:0] rel_sh, rel_ap, win_sh, win_ap;
  logic             pend_p, pend_r, pend_w;
  logic             frozen, run_en, strobe, load, expire;
  logic [CNT_W-1:0] cnt;
  logic             win_viol;
  logic             sticky;
  logic             sticky_clr;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  wdg_key_decode u_key (
    .clk(clk), .rst_n(rst_n),
    .key_wr(wr_fire && (wr_addr == A_KEY)),
    .key_val(wr_data), .evt(kev), .unlocked(unlocked)
  );

  assign presc_we  = wr_fire && unlocked && (wr_addr == A_PRESC);
  assign reload_we = wr_fire && unlocked && (wr_addr == A_RELOAD);
  assign window_we = wr_fire && unlocked && (wr_addr == A_WINDOW);

  wdg_cfg_slot #(.W(SEL_W), .RST_VAL('0), .UPD_TICKS(UPD_TICKS)) u_presc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(presc_we),
    .wr_val(wr_data[SEL_W-1:0]), .shadow(presc_sh), .applied(presc_ap), .pending(pend_p)
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_reload (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(reload_we),
    .wr_val(wr_data[CNT_W-1:0]), .shadow(rel_sh), .applied(rel_ap), .pending(pend_r)
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(window_we),
    .wr_val(wr_data[CNT_W-1:0]), .shadow(win_sh), .applied(win_ap), .pending(pend_w)
  );

  // Running state: set by start key or the static start option, cleared only by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     active <= 1'b0;
    else if (kev.start || hw_start) active <= 1'b1;
  end

  assign frozen = freeze_cfg && dbg_halt;
  assign run_en = active && slow_tick && !frozen;
  assign load   = kev.refresh || window_we;

  wdg_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .PRE_W(MAX_SEL + 2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart(load),
    .sel(presc_ap), .strobe(strobe)
  );

  wdg_downcounter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .load(load),
    .load_val(rel_ap), .cnt(cnt), .expire(expire)
  );

  assign win_viol = active && kev.refresh && (win_ap != WIN_OFF) && (cnt > win_ap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_reset <= 1'b0;
    else        wdt_reset <= expire || win_viol;
  end

  assign sticky_clr = wr_fire && (wr_addr == A_STATUS) && wr_data[STICKY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sticky <= 1'b0;
    else if (wdt_reset)  sticky <= 1'b1;
    else if (sticky_clr) sticky <= 1'b0;
  end

  always_comb begin
    unique case (rd_addr)
      A_PRESC:  rd_data = DATA_W'(presc_sh);
      A_RELOAD: rd_data = DATA_W'(rel_sh);
      A_WINDOW: rd_data = DATA_W'(win_sh);
      A_STATUS: rd_data = DATA_W'({sticky, pend_w, pend_r, pend_p});
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_checks.sv
module keyed_wdt_checks
  import wdg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_reset,
  input logic              active,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              unlocked,
  input logic              pend_r,
  input logic [CNT_W-1:0]  rel_sh,
  input logic              sticky
);
  // R5: reset output is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  // R2: once running, the watchdog cannot be stopped
  a_r2_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);

  // R3: a write to a protected register while locked leaves it unchanged
  a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == A_RELOAD && !unlocked) |=> $stable(rel_sh));

  // R7: an accepted reload write raises its pending flag
  a_r7_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == A_RELOAD && unlocked) |=> pend_r);

  // R11: every pulse leaves the sticky flag set
  a_r11_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> sticky);
endmodule

bind keyed_wdt keyed_wdt_checks u_checks (
  .clk(clk), .rst_n(rst_n), .wdt_reset(wdt_reset), .active(active),
  .wr_fire(wr_fire), .wr_addr(wr_addr), .unlocked(unlocked),
  .pend_r(pend_r), .rel_sh(rel_sh), .sticky(sticky)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b1;
  logic        hw_start = 1'b0;
  logic        freeze_cfg = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        active;
  logic        wdt_reset;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .hw_start(hw_start),
    .freeze_cfg(freeze_cfg), .dbg_halt(dbg_halt), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .active(active), .wdt_reset(wdt_reset)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic to_pulse(input int lim, output int n);
    n = 0;
    while (!wdt_reset && n < lim) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset(input logic hs);
    hw_start = hs;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset_state;
    int v;
    check("R1 active", int'(active), 0);
    check("R1 wdt_reset", int'(wdt_reset), 0);
    rd(3'd1, v); check("R1 prescaler", v, 0);
    rd(3'd2, v); check("R1 reload", v, 'hFFF);
    rd(3'd3, v); check("R1 window", v, 'hFFF);
    rd(3'd4, v); check("R1 status", v, 0);
  endtask

  task automatic t_lock;
    int v;
    wr(3'd2, 16'h0123);
    rd(3'd2, v); check("R3 locked write ignored", v, 'hFFF);
    rd(3'd4, v); check("R3 no pending when locked", v, 0);
    wr(3'd0, 16'h5555);
    wr(3'd2, 16'h0123);
    rd(3'd2, v); check("R3 unlocked write", v, 'h123);
    wr(3'd0, 16'h1234);
    wr(3'd2, 16'h0456);
    rd(3'd2, v); check("R3 relock by bad key", v, 'h123);
  endtask

  task automatic t_pending;
    int v;
    wr(3'd0, 16'h5555);
    wr(3'd2, 16'h0010);
    rd(3'd4, v); check("R7 reload pending set", v, 'h2);
    idle(2);
    rd(3'd4, v); check("R7 still pending", v, 'h2);
    idle(8);
    rd(3'd4, v); check("R7 pending cleared", v, 0);
  endtask

  task automatic t_start;
    wr(3'd0, 16'hCCCC);
    check("R2 started", int'(active), 1);
    wr(3'd0, 16'h0000);
    idle(2);
    check("R2 cannot stop", int'(active), 1);
  endtask

  task automatic t_expiry;
    int n, v;
    wr(3'd0, 16'hAAAA);
    to_pulse(1000, n); check("R4 expiry cycles", n, 64);
    @(negedge clk);
    check("R5 pulse one cycle", int'(wdt_reset), 0);
    to_pulse(1000, n); check("R5 rearm cycles", n, 67);
    rd(3'd4, v); check("R11 sticky set", v, 'h8);
    wr(3'd0, 16'hAAAA);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); check("R11 sticky cleared", v, 0);
  endtask

  task automatic t_presc;
    int n;
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'h0001);
    idle(10);
    wr(3'd0, 16'hAAAA);
    to_pulse(2000, n); check("R6 divide by 8", n, 128);
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'h0007);
    idle(10);
    wr(3'd0, 16'hAAAA);
    to_pulse(10000, n); check("R6 clamp to 256", n, 4096);
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'h0000);
    idle(10);
  endtask

  task automatic t_window;
    int n;
    wr(3'd0, 16'h5555);
    wr(3'd3, 16'h0008);
    to_pulse(1000, n); check("R8 window write reloads", n, 64);
    wr(3'd0, 16'hAAAA);
    check("R9 refresh at zero allowed", int'(wdt_reset), 0);
    wr(3'd0, 16'hAAAA);
    check("R9 early refresh fires", int'(wdt_reset), 1);
    idle(40);
    wr(3'd0, 16'hAAAA);
    check("R9 refresh in window allowed", int'(wdt_reset), 0);
    wr(3'd0, 16'h5555);
    wr(3'd3, 16'h0FFF);
    idle(10);
    wr(3'd0, 16'hAAAA);
  endtask

  task automatic t_freeze;
    int n;
    logic seen;
    freeze_cfg = 1'b1;
    dbg_halt = 1'b1;
    wr(3'd0, 16'hAAAA);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wdt_reset) seen = 1'b1;
    end
    check("R10 frozen no pulse", int'(seen), 0);
    dbg_halt = 1'b0;
    wr(3'd0, 16'hAAAA);
    to_pulse(1000, n); check("R10 resumes", n, 64);
    freeze_cfg = 1'b0;
    dbg_halt = 1'b1;
    wr(3'd0, 16'hAAAA);
    to_pulse(1000, n); check("R10 halt ignored without freeze", n, 64);
    dbg_halt = 1'b0;
  endtask

  task automatic t_hw_start;
    do_reset(1'b1);
    check("R2 hardware start", int'(active), 1);
    do_reset(1'b0);
    check("R2 reset clears active", int'(active), 0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_lock();
    t_pending();
    t_start();
    t_expiry();
    t_presc();
    t_window();
    t_freeze();
    t_hw_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule